// File: doc/BRIEF.md
# Bus-Programmed Down-Counting Interval Timer

This block is a 32-bit interval timer that sits on a simple word-addressed register bus with 16-bit data. Software loads a 32-bit period through two 16-bit halves, each of which also reloads the live counter at once. Control bits start and stop counting and pick between one-shot and continuous operation.

Each enabled clock cycle lowers the live count by a fixed step. When the count would reach zero it reloads from the period and raises a timeout flag. A registered interrupt follows that flag while it is enabled. Reading either snapshot offset captures the live count at the cycle of the read strobe.

Register offsets, with byte address equal to offset times four: 0 status, 1 control, 2 period bits 15:0, 3 period bits 31:16, 4 snapshot bits 15:0, 5 snapshot bits 31:16. Status bit 0 is the timeout flag and bit 1 is the run indication. Control bit 0 enables the interrupt, bit 1 selects continuous mode, bit 2 is start and bit 3 is stop.

Top module: `tmr_interval_top`

## Requirements
- R1: After reset every register reads zero, the counter is stopped, `irq_o` is 0 and `bus_rdata` is 0.
- R2: Control reads back only its 4 low bits, status only its 2 low bits, and all upper bits read zero. Offsets 6 and 7 read zero, and writes to them have no effect.
- R3: A write to offset 2 replaces period bits 15:0, and a write to offset 3 replaces bits 31:16. Either write loads the full new period into the live counter on the same edge, and this takes priority over a tick in that cycle.
- R4: While start (control bit 2) is 1, stop (control bit 3) is 0 and the counter is not parked, the count drops by 2 on every clock edge. Otherwise the count holds.
- R5: On a tick where the count is 2 or less, the counter instead reloads the stored period and status bit 0 (timeout) becomes 1.
- R6: With continuous (control bit 1) at 0, a timeout reload parks the counter until the next write to control or to a period half. With continuous at 1, counting goes on through reloads.
- R7: `irq_o` equals (control bit 0 AND timeout) delayed by one clock.
- R8: Writing status sets timeout to write-data bit 0. A timeout in the same cycle wins over a clearing write. Status bit 1 ignores writes.
- R9: A read of offset 4 or 5 returns the low or high half of the live count as it stood just before the edge that samples the read strobe. Every such read makes a fresh capture.
- R10: Read data appears on `bus_rdata` one cycle after the read strobe and holds until the next read.
- R11: Status bit 1 (run) is 1 exactly while the counter is enabled to tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Selects the block for an access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
Two pairs of functions can collide in one cycle. In the first, software clears status while the counter wraps. The bench times a status write of zero so that it is sampled on the very edge where a period-4 count goes from 2 to a reload, then stops the timer one tick later, before any further wrap. It reads status back and expects the timeout flag still set. In the second, a period write lands while the counter is running, and the bench checks that the count restarts from the new period rather than from a decremented value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned REG_W = 16;
    localparam int unsigned CNT_W = 2 * REG_W;
    localparam int unsigned OFS_W = 3;

    typedef enum logic [OFS_W-1:0] {
        OFS_STATUS  = 3'd0,
        OFS_CTRL    = 3'd1,
        OFS_PER_LO  = 3'd2,
        OFS_PER_HI  = 3'd3,
        OFS_SNAP_LO = 3'd4,
        OFS_SNAP_HI = 3'd5
    } reg_ofs_e;

    // control word, msb first: halt, go, loop, irq_en
    typedef struct packed {
        logic halt;
        logic go;
        logic loop;
        logic irq_en;
    } ctrl_t;

    typedef struct packed {
        logic run;
        logic tmo;
    } stat_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);
    localparam int unsigned STAT_W = $bits(stat_t);

    function automatic logic [CNT_W-1:0] merge_half(
        input logic [CNT_W-1:0] cur,
        input logic             upper,
        input logic [REG_W-1:0] half
    );
        logic [CNT_W-1:0] res;
        res = cur;
        if (upper) res[CNT_W-1:REG_W] = half;
        else       res[REG_W-1:0]     = half;
        return res;
    endfunction

endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic             wr,
    input  logic             rd,
    input  logic [OFS_W-1:0] addr,
    input  logic [REG_W-1:0] wdata,
    input  logic [CNT_W-1:0] live_cnt,
    input  logic             run,
    input  logic             wrap,
    output logic [REG_W-1:0] rdata,
    output ctrl_t            ctrl,
    output logic             tmo,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] period_nxt,
    output logic             per_load,
    output logic             ctrl_wr
);

    logic             wr_hit, rd_hit, stat_wr;
    logic             tmo_d;
    logic [REG_W-1:0] rd_val;
    stat_t            stat_view;

    assign wr_hit   = sel & wr;
    assign rd_hit   = sel & rd;
    assign stat_wr  = wr_hit & (addr == OFS_STATUS);
    assign ctrl_wr  = wr_hit & (addr == OFS_CTRL);
    assign per_load = wr_hit & ((addr == OFS_PER_LO) | (addr == OFS_PER_HI));

    assign period_nxt = merge_half(period, addr == OFS_PER_HI, wdata);

    always_comb begin
        tmo_d = tmo;
        if (stat_wr) tmo_d = wdata[0];
        if (wrap)    tmo_d = 1'b1;
    end

    assign stat_view = '{run: run, tmo: tmo};

    always_comb begin
        case (addr)
            OFS_STATUS:  rd_val = REG_W'(stat_view);
            OFS_CTRL:    rd_val = REG_W'(ctrl);
            OFS_PER_LO:  rd_val = period[REG_W-1:0];
            OFS_PER_HI:  rd_val = period[CNT_W-1:REG_W];
            OFS_SNAP_LO: rd_val = live_cnt[REG_W-1:0];
            OFS_SNAP_HI: rd_val = live_cnt[CNT_W-1:REG_W];
            default:     rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            tmo    <= 1'b0;
            period <= '0;
            rdata  <= '0;
        end else begin
            tmo <= tmo_d;
            if (ctrl_wr)  ctrl   <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (per_load) period <= period_nxt;
            if (rd_hit)   rdata  <= rd_val;
        end
    end

    a_r5_tmo_set: assert property (@(posedge clk) disable iff (rst)
        wrap |=> tmo);

    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !wdata[0] && !wrap) |=> !tmo);

    a_r2_ctrl_pad: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && addr == OFS_CTRL) |=> (rdata[REG_W-1:CTRL_W] == '0));

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |=> $stable(rdata));

endmodule

// File: rtl/tmr_engine.sv
module tmr_engine
    import tmr_pkg::*;
#(
    parameter int unsigned STEP = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] period_nxt,
    input  logic             per_load,
    input  logic             ctrl_wr,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

    logic parked, parked_d;

    assign run  = ctrl.go & ~ctrl.halt & ~parked;
    assign wrap = run & ~per_load & (cnt <= STEP_V);

    always_comb begin
        parked_d = parked;
        if (ctrl_wr || per_load) parked_d = 1'b0;
        if (wrap)                parked_d = ~ctrl.loop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            parked <= 1'b0;
        end else begin
            parked <= parked_d;
            if (per_load)  cnt <= period_nxt;
            else if (wrap) cnt <= period;
            else if (run)  cnt <= cnt - STEP_V;
        end
    end

    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        (run && !per_load && cnt > STEP_V) |=> (cnt == $past(cnt) - STEP_V));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !per_load) |=> $stable(cnt));

    a_r5_reload: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == $past(period)));

    a_r6_park: assert property (@(posedge clk) disable iff (rst)
        (wrap && !ctrl.loop) |=> !run);

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  tmo,
    output logic  irq
);

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= ctrl.irq_en & tmo;
    end

    a_r7_irq_off: assert property (@(posedge clk) disable iff (rst)
        !ctrl.irq_en |=> !irq);

    a_r7_irq_on: assert property (@(posedge clk) disable iff (rst)
        (ctrl.irq_en && tmo) |=> irq);

endmodule

// File: rtl/tmr_interval_top.sv
module tmr_interval_top
    import tmr_pkg::*;
#(
    parameter int unsigned STEP = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [OFS_W-1:0] bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             irq_o
);

    ctrl_t            ctrl;
    logic             tmo, run, wrap, per_load, ctrl_wr;
    logic [CNT_W-1:0] period, period_nxt, cnt;

    tmr_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .sel        (bus_sel),
        .wr         (bus_wr),
        .rd         (bus_rd),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .live_cnt   (cnt),
        .run        (run),
        .wrap       (wrap),
        .rdata      (bus_rdata),
        .ctrl       (ctrl),
        .tmo        (tmo),
        .period     (period),
        .period_nxt (period_nxt),
        .per_load   (per_load),
        .ctrl_wr    (ctrl_wr)
    );

    tmr_engine #(.STEP(STEP)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .period     (period),
        .period_nxt (period_nxt),
        .per_load   (per_load),
        .ctrl_wr    (ctrl_wr),
        .cnt        (cnt),
        .run        (run),
        .wrap       (wrap)
    );

    tmr_irq u_irq (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl),
        .tmo  (tmo),
        .irq  (irq_o)
    );

    a_r3_load: assert property (@(posedge clk) disable iff (rst)
        per_load |=> (cnt == period));

    a_r2_unmapped: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr > 3'd5) |=> ($stable(ctrl) && $stable(period)));

endmodule

// File: tb/tmr_interval_tb.sv
module tmr_interval_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [15:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    logic rd_seen = 1'b0;

    always #5 clk = ~clk;

    tmr_interval_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: result of a read sampled on the previous posedge
    always @(posedge clk) rd_seen <= bus_sel & bus_rd & ~rst;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R10: actual=%h expected=<none queued>", bus_rdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, bus_rdata, e.val);
            end
        end
    end

    // tasks start and end at a negedge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
        exp_t e;
        e.val = exp; e.tag = tag;
        exp_q.push_back(e);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        idle(2);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R10: actual=%0d reads pending expected=0", exp_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 irq", {15'b0, irq_o}, 16'h0);
        check("R1 rdata", bus_rdata, 16'h0);
        rd(3'd0, 16'h0, "R1 status");
        rd(3'd1, 16'h0, "R1 ctrl");
        rd(3'd2, 16'h0, "R1 per_lo");
        rd(3'd3, 16'h0, "R1 per_hi");
        rd(3'd4, 16'h0, "R1 R9 snap_lo");
        rd(3'd5, 16'h0, "R1 R9 snap_hi");

        // R2: masking and unmapped offsets; R8 run bit read-only
        wr(3'd1, 16'hFFFF);
        rd(3'd1, 16'h000F, "R2 ctrl pad");
        wr(3'd0, 16'hFFFF);
        rd(3'd0, 16'h0001, "R2 R8 status pad");
        wr(3'd0, 16'h0000);
        rd(3'd0, 16'h0000, "R8 status clear");
        wr(3'd6, 16'h1234);
        rd(3'd6, 16'h0000, "R2 ofs6");
        rd(3'd7, 16'h0000, "R2 ofs7");
        rd(3'd1, 16'h000F, "R2 ctrl after unmapped write");
        wr(3'd1, 16'h0000);

        // R3 R4 R11: period across halves, run, freeze
        wr(3'd2, 16'h0000);
        wr(3'd3, 16'h0001);
        rd(3'd2, 16'h0000, "R3 per_lo");
        rd(3'd3, 16'h0001, "R3 per_hi");
        rd(3'd4, 16'h0000, "R3 load lo");
        rd(3'd5, 16'h0001, "R3 load hi");
        wr(3'd1, 16'h0004);               // start at E0
        rd(3'd0, 16'h0002, "R11 run high");  // E1
        idle(8);                          // E2..E9
        wr(3'd1, 16'h000C);               // E10, 10 ticks total
        rd(3'd4, 16'hFFEC, "R4 count lo");
        rd(3'd5, 16'h0000, "R4 count hi");
        idle(5);
        rd(3'd4, 16'hFFEC, "R4 stop freezes");
        rd(3'd0, 16'h0000, "R11 run low");

        // R3: period write while running wins over tick
        wr(3'd1, 16'h0004);               // E0
        idle(2);                          // E1,E2
        wr(3'd2, 16'h0100);               // E3 load 0x00010100
        wr(3'd1, 16'h000C);               // E4 tick
        rd(3'd4, 16'h00FE, "R3 reload on write lo");
        rd(3'd5, 16'h0001, "R3 reload on write hi");

        // R5: continuous wrap
        wr(3'd3, 16'h0000);
        wr(3'd2, 16'd10);
        wr(3'd1, 16'h0006);               // E0
        idle(5);                          // E1..E5
        wr(3'd1, 16'h000E);               // E6: 10,8,6,4,2,10,8
        rd(3'd4, 16'd8, "R5 wrap reload count");
        rd(3'd0, 16'h0001, "R5 timeout set");
        check("R7 irq disabled", {15'b0, irq_o}, 16'h0);
        wr(3'd0, 16'h0000);
        rd(3'd0, 16'h0000, "R8 clear after wrap");

        // R6: one-shot parks, control write restarts
        wr(3'd2, 16'd6);
        wr(3'd1, 16'h0004);               // 6,4,2,6 park
        idle(6);
        rd(3'd0, 16'h0001, "R6 R11 parked");
        rd(3'd4, 16'd6, "R6 parked count");
        wr(3'd1, 16'h0004);
        rd(3'd0, 16'h0003, "R6 restart via ctrl");
        wr(3'd1, 16'h000C);
        wr(3'd0, 16'h0000);

        // R7: irq lag
        wr(3'd1, 16'h0009);
        wr(3'd0, 16'h0001);
        check("R7 irq lag rise", {15'b0, irq_o}, 16'h0);
        idle(1);
        check("R7 irq high", {15'b0, irq_o}, 16'h1);
        wr(3'd0, 16'h0000);
        check("R7 irq lag fall", {15'b0, irq_o}, 16'h1);
        idle(1);
        check("R7 irq low", {15'b0, irq_o}, 16'h0);

        // R8: clear collides with wrap
        wr(3'd2, 16'd4);
        wr(3'd1, 16'h0007);               // E0
        idle(1);                          // E1: 4->2
        wr(3'd0, 16'h0000);               // E2: wrap, timeout wins
        wr(3'd1, 16'h000F);               // E3: 4->2, stop
        rd(3'd0, 16'h0001, "R8 wrap beats clear");
        rd(3'd4, 16'd2, "R8 count after collision");
        check("R7 irq after collision", {15'b0, irq_o}, 16'h1);
        wr(3'd0, 16'h0000);

        // R9: each snapshot read is a fresh live capture
        wr(3'd2, 16'd100);
        wr(3'd1, 16'h0006);               // E0
        rd(3'd4, 16'd100, "R9 capture first");   // E1
        rd(3'd4, 16'd98, "R9 capture second");   // E2
        rd(3'd5, 16'd0, "R9 capture hi");
        wr(3'd1, 16'h000E);

        finish_run();
    end

endmodule